// File: doc/BRIEF.md
# Hardware Standby Power-Mode Controller

This block sequences the clock and power modes of a processor subsystem. It covers normal run, sleep, software standby, the watchdog settling phase that follows a wake-up from software standby, and a hardware standby state that is requested through an active-low pin. The outputs are a clock-run enable for each clock domain, an enable for the timer unit, a gated timer clock, a mask that says whether interrupts and manual resets are accepted, and a one-cycle pulse that tells the CPU to start power-on reset processing.

The effect of a hardware standby request depends on the mode the block is in. From run or software standby the block stops the clocks at once. From sleep or watchdog settling it waits until the CPU has resumed. Once in hardware standby, no wake event brings the block back. Only a fixed pin order leaves it: raise the standby pin while the power-on reset pin is still low, let the oscillator-stabilization counter run, then release the reset pin. A stable flag reports that the counter has finished. A second flag records a reset release that came too early.

Top module: `hw_standby_ctrl`

## Requirements
- R1: `stby_req_ni` and `por_ni` each pass through a two-flop synchronizer. A pin change applied between two rising edges does not affect `mode_o` after the first or second following edge, and does take effect after the third.
- R2: `mode_o` encodes 0 = run, 1 = sleep, 2 = software standby, 3 = watchdog settling, 4 = hardware standby, 5 = oscillator restart. After `rst_ni` the mode is run, every clock enable is high and `accept_o` is high.
- R3: In run, a low standby request moves the block to hardware standby and takes priority over CPU commands. Otherwise `stby_cmd_i` moves it to software standby and `sleep_cmd_i` moves it to sleep. When both commands arrive together, standby wins.
- R4: In hardware standby, `clk_en_o` has only bit RTC_DOM (default 0) set, `tmu_en_o` is low and `tclk_o` is held low.
- R5: In hardware standby and oscillator restart, `accept_o` is low and `irq_i` and `mrst_req_i` leave the mode unchanged.
- R6: In software standby, a low standby request moves the block directly to hardware standby, with no run cycle in between and with the clocks kept stopped.
- R7: In watchdog settling, a low standby request is held off. When `wdt_done_i` arrives the block spends one cycle in run and then enters hardware standby.
- R8: In sleep, a low standby request is held off. `irq_i` or `mrst_req_i` returns the block to run for one cycle, after which it enters hardware standby.
- R9: In hardware standby, raising the standby pin while the reset pin is low moves the block to oscillator restart. Raising it while the reset pin is high leaves the block in hardware standby. In oscillator restart, a low standby pin sends the block back to hardware standby.
- R10: In oscillator restart, a high reset pin moves the block to run. `por_start_o` is high for exactly the first run cycle.
- R11: `osc_stable_o` rises exactly STAB_CYC cycles after oscillator restart is entered. `osc_early_o` is set when the reset release ends oscillator restart while `osc_stable_o` is still low. Both flags clear on the next entry to oscillator restart.
- R12: In run, every clock enable is high. In sleep, only bit CPU_DOM (default 1) is low. In software standby and settling, only bit RTC_DOM is high. While `tmu_en_o` is high, that is in every mode except hardware standby and oscillator restart, `tclk_o` toggles every cycle.
- R13: In software standby, `irq_i` or `mrst_req_i` moves the block to watchdog settling. The block stays in settling until `wdt_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stby_req_ni | input | 1 | Hardware standby request pin, active low |
| por_ni | input | 1 | Power-on reset pin, active low |
| irq_i | input | 1 | Interrupt request |
| mrst_req_i | input | 1 | Manual reset request |
| sleep_cmd_i | input | 1 | CPU sleep command pulse |
| stby_cmd_i | input | 1 | CPU software standby command pulse |
| wdt_done_i | input | 1 | Watchdog settling finished |
| clk_en_o | output | N_DOM | Clock-run enable per domain |
| tmu_en_o | output | 1 | Timer unit enable |
| tclk_o | output | 1 | Gated timer clock output |
| accept_o | output | 1 | Interrupt and manual reset acceptance |
| por_start_o | output | 1 | Power-on reset processing start pulse |
| osc_stable_o | output | 1 | Oscillator stabilization complete |
| osc_early_o | output | 1 | Reset released before stabilization |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the block with N_DOM = 4, RTC_DOM = 0, CPU_DOM = 1 and STAB_CYC = 20. The short stabilization window lets directed sequences observe the exact cycle on which the stable flag rises. It also lets random pin toggling reach oscillator restart often, and from there both the early-release path and the fully stabilized path. With four domains the sleep pattern, which drops only the CPU bit, is distinct from the standby pattern, which keeps only the real-time-clock bit.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_SLEEP  = 3'd1,
    MODE_SWSTBY = 3'd2,
    MODE_SETTLE = 3'd3,
    MODE_HWSTBY = 3'd4,
    MODE_OSCRST = 3'd5
  } hsc_mode_e;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/hsc_fsm.sv
module hsc_fsm
  import hsc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_n_i,
  input  logic      por_n_i,
  input  logic      irq_i,
  input  logic      mrst_i,
  input  logic      sleep_i,
  input  logic      stby_i,
  input  logic      wdt_done_i,
  output hsc_mode_e mode_o,
  output logic      osc_enter_o,
  output logic      osc_exit_o,
  output logic      por_start_o
);
  hsc_mode_e state_q, state_d;
  logic      wake;
  logic      pstart_q;

  assign wake = irq_i | mrst_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_RUN: begin
        if (!req_n_i)    state_d = MODE_HWSTBY;
        else if (stby_i) state_d = MODE_SWSTBY;
        else if (sleep_i) state_d = MODE_SLEEP;
      end
      MODE_SLEEP:  if (wake) state_d = MODE_RUN;
      MODE_SWSTBY: begin
        if (!req_n_i)  state_d = MODE_HWSTBY;
        else if (wake) state_d = MODE_SETTLE;
      end
      MODE_SETTLE: if (wdt_done_i) state_d = MODE_RUN;
      MODE_HWSTBY: if (req_n_i && !por_n_i) state_d = MODE_OSCRST;
      MODE_OSCRST: begin
        if (!req_n_i)    state_d = MODE_HWSTBY;
        else if (por_n_i) state_d = MODE_RUN;
      end
      default: state_d = MODE_RUN;
    endcase
  end

  assign osc_enter_o = (state_q != MODE_OSCRST) && (state_d == MODE_OSCRST);
  assign osc_exit_o  = (state_q == MODE_OSCRST) && (state_d == MODE_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= MODE_RUN;
      pstart_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pstart_q <= osc_exit_o;
    end
  end

  assign mode_o      = state_q;
  assign por_start_o = pstart_q;

  assert_hw_ignores_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_HWSTBY && wake && !req_n_i) |=> state_q == MODE_HWSTBY);
  assert_sw_direct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_SWSTBY && !req_n_i) |=> state_q == MODE_HWSTBY);
  assert_sleep_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_SLEEP && !wake) |=> state_q == MODE_SLEEP);
  assert_settle_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_SETTLE && !wdt_done_i) |=> state_q == MODE_SETTLE);
  assert_pstart_after_osc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_start_o) |-> ($past(state_q) == MODE_OSCRST && state_q == MODE_RUN));
  assert_pstart_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_start_o |=> !por_start_o);
endmodule

// File: rtl/hsc_osc_cnt.sv
module hsc_osc_cnt #(
  parameter int STAB_CYC = 1024,
  localparam int CNT_W   = $clog2(STAB_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic rel_i,
  output logic stable_o,
  output logic early_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYC);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(STAB_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q, early_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
      early_q  <= 1'b0;
    end else begin
      if (!run_i)             cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;

      if (clr_i)                        stable_q <= 1'b0;
      else if (run_i && cnt_q == PRE)   stable_q <= 1'b1;

      if (clr_i)                   early_q <= 1'b0;
      else if (rel_i && !stable_q) early_q <= 1'b1;
    end
  end

  assign stable_o = stable_q;
  assign early_o  = early_q;

  assert_stable_rises_in_osc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_o) |-> $past(run_i));
  assert_clr_drops_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!stable_o && !early_o));
endmodule

// File: rtl/hsc_clk_out.sv
module hsc_clk_out
  import hsc_pkg::*;
#(
  parameter int N_DOM   = 4,
  parameter int RTC_DOM = 0,
  parameter int CPU_DOM = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  hsc_mode_e        mode_i,
  output logic [N_DOM-1:0] clk_en_o,
  output logic             tmu_en_o,
  output logic             tclk_o,
  output logic             accept_o
);
  logic run_m, sleep_m, locked_m;
  logic tclk_q;

  assign run_m    = (mode_i == MODE_RUN);
  assign sleep_m  = (mode_i == MODE_SLEEP);
  assign locked_m = (mode_i == MODE_HWSTBY) || (mode_i == MODE_OSCRST);

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    if (d == RTC_DOM) begin : g_rtc
      assign clk_en_o[d] = 1'b1;
    end else if (d == CPU_DOM) begin : g_cpu
      assign clk_en_o[d] = run_m;
    end else begin : g_per
      assign clk_en_o[d] = run_m | sleep_m;
    end
  end

  assign tmu_en_o = !locked_m;
  assign accept_o = !locked_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tclk_q <= 1'b0;
    else if (tmu_en_o) tclk_q <= ~tclk_q;
    else               tclk_q <= 1'b0;
  end

  assign tclk_o = tclk_q & tmu_en_o;
endmodule

// File: rtl/hw_standby_ctrl.sv
module hw_standby_ctrl
  import hsc_pkg::*;
#(
  parameter int N_DOM    = 4,
  parameter int RTC_DOM  = 0,
  parameter int CPU_DOM  = 1,
  parameter int STAB_CYC = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stby_req_ni,
  input  logic             por_ni,
  input  logic             irq_i,
  input  logic             mrst_req_i,
  input  logic             sleep_cmd_i,
  input  logic             stby_cmd_i,
  input  logic             wdt_done_i,
  output logic [N_DOM-1:0] clk_en_o,
  output logic             tmu_en_o,
  output logic             tclk_o,
  output logic             accept_o,
  output logic             por_start_o,
  output logic             osc_stable_o,
  output logic             osc_early_o,
  output logic [2:0]       mode_o
);
  localparam logic [N_DOM-1:0] RTC_ONLY = N_DOM'(1) << RTC_DOM;

  logic [1:0] pins_s;
  hsc_mode_e  mode_w;
  logic       osc_enter, osc_exit;

  hsc_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({por_ni, stby_req_ni}),
    .q_o    (pins_s)
  );

  hsc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_n_i     (pins_s[0]),
    .por_n_i     (pins_s[1]),
    .irq_i       (irq_i),
    .mrst_i      (mrst_req_i),
    .sleep_i     (sleep_cmd_i),
    .stby_i      (stby_cmd_i),
    .wdt_done_i  (wdt_done_i),
    .mode_o      (mode_w),
    .osc_enter_o (osc_enter),
    .osc_exit_o  (osc_exit),
    .por_start_o (por_start_o)
  );

  hsc_osc_cnt #(.STAB_CYC(STAB_CYC)) u_osc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (mode_w == MODE_OSCRST),
    .clr_i    (osc_enter),
    .rel_i    (osc_exit),
    .stable_o (osc_stable_o),
    .early_o  (osc_early_o)
  );

  hsc_clk_out #(.N_DOM(N_DOM), .RTC_DOM(RTC_DOM), .CPU_DOM(CPU_DOM)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_w),
    .clk_en_o (clk_en_o),
    .tmu_en_o (tmu_en_o),
    .tclk_o   (tclk_o),
    .accept_o (accept_o)
  );

  assign mode_o = mode_w;

  assert_hw_outputs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> (clk_en_o == RTC_ONLY && !tmu_en_o && !tclk_o));
  assert_no_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 || mode_o == 3'd5) |-> !accept_o);
  assert_exit_needs_osc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd4 && mode_o != 3'd4) |-> mode_o == 3'd5);
endmodule

// File: tb/hw_standby_ctrl_tb_top.sv
module hw_standby_ctrl_tb_top;
  localparam int ND   = 4;
  localparam int STAB = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stby_req_ni = 1'b1, por_ni = 1'b1;
  logic irq_i = 1'b0, mrst_req_i = 1'b0, sleep_cmd_i = 1'b0, stby_cmd_i = 1'b0, wdt_done_i = 1'b0;
  logic [ND-1:0] clk_en_o;
  logic tmu_en_o, tclk_o, accept_o, por_start_o, osc_stable_o, osc_early_o;
  logic [2:0] mode_o;

  int total = 0, bad = 0;
  bit model_chk = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hw_standby_ctrl #(.N_DOM(ND), .RTC_DOM(0), .CPU_DOM(1), .STAB_CYC(STAB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .stby_req_ni(stby_req_ni), .por_ni(por_ni),
    .irq_i(irq_i), .mrst_req_i(mrst_req_i), .sleep_cmd_i(sleep_cmd_i),
    .stby_cmd_i(stby_cmd_i), .wdt_done_i(wdt_done_i), .clk_en_o(clk_en_o),
    .tmu_en_o(tmu_en_o), .tclk_o(tclk_o), .accept_o(accept_o),
    .por_start_o(por_start_o), .osc_stable_o(osc_stable_o),
    .osc_early_o(osc_early_o), .mode_o(mode_o));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nxt(int m, bit rq, bit pr, bit irq, bit mr, bit sl, bit sb, bit wd);
    case (m)
      0: return !rq ? 4 : sb ? 2 : sl ? 1 : 0;
      1: return (irq || mr) ? 0 : 1;
      2: return !rq ? 4 : (irq || mr) ? 3 : 2;
      3: return wd ? 0 : 3;
      4: return (rq && !pr) ? 5 : 4;
      5: return !rq ? 4 : pr ? 0 : 5;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_en(int m);
    case (m)
      0: return 4'b1111;
      1: return 4'b1101;
      2, 3, 4, 5: return 4'b0001;
      default: return 0;
    endcase
  endfunction

  function automatic bit tmu_on(int m);
    return !(m == 4 || m == 5);
  endfunction

  // reference model, updated just after each rising edge
  int em = 0, ecnt = 0;
  bit rs1 = 1, rs2 = 1, ps1 = 1, ps2 = 1, estb = 0, eerl = 0, epst = 0, etq = 0;
  always @(posedge clk_i) begin
    #1;
    if (!rst_ni) begin
      em = 0; ecnt = 0; rs1 = 1; rs2 = 1; ps1 = 1; ps2 = 1;
      estb = 0; eerl = 0; epst = 0; etq = 0;
    end else begin
      int nm;
      nm = nxt(em, rs2, ps2, irq_i, mrst_req_i, sleep_cmd_i, stby_cmd_i, wdt_done_i);
      epst = (em == 5 && nm == 0);
      if (em != 5 && nm == 5) begin
        estb = 0; eerl = 0;
      end else begin
        if (em == 5 && ecnt == STAB - 1) estb = 1;
        if (epst && !estb) eerl = 1;
      end
      if (em == 5 && epst && ecnt == STAB - 1) eerl = 1;
      ecnt = (em == 5) ? ((ecnt == STAB) ? ecnt : ecnt + 1) : 0;
      etq = tmu_on(em) ? ~etq : 1'b0;
      em = nm;
      rs2 = rs1; rs1 = stby_req_ni;
      ps2 = ps1; ps1 = por_ni;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && model_chk) begin
      chk("R2 mode", int'(mode_o), em);
      chk("R12 clk_en", int'(clk_en_o), exp_en(em));
      chk("R4 tmu_en", int'(tmu_en_o), int'(tmu_on(em)));
      chk("R5 accept", int'(accept_o), int'(tmu_on(em)));
      chk("R12 tclk", int'(tclk_o), int'(etq & tmu_on(em)));
      chk("R10 por_start", int'(por_start_o), int'(epst));
      chk("R11 stable", int'(osc_stable_o), int'(estb));
      chk("R11 early", int'(osc_early_o), int'(eerl));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic hw_to_run();
    por_ni = 1'b0; stby_req_ni = 1'b1; cyc(4);
    por_ni = 1'b1; cyc(4);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R2 reset mode", int'(mode_o), 0);
    chk("R2 reset clk_en", int'(clk_en_o), 4'hF);
    chk("R2 reset accept", int'(accept_o), 1);
    model_chk = 1'b1;

    pulse(sleep_cmd_i);
    chk("R3 sleep", int'(mode_o), 1);
    chk("R12 sleep clk_en", int'(clk_en_o), 4'b1101);
    pulse(irq_i);
    chk("R8 wake", int'(mode_o), 0);

    sleep_cmd_i = 1'b1; stby_cmd_i = 1'b1; cyc(1);
    sleep_cmd_i = 1'b0; stby_cmd_i = 1'b0;
    chk("R3 stby priority", int'(mode_o), 2);
    chk("R12 swstby clk_en", int'(clk_en_o), 4'b0001);
    pulse(irq_i);
    chk("R13 settle", int'(mode_o), 3);
    cyc(5);
    chk("R13 settle hold", int'(mode_o), 3);
    pulse(wdt_done_i);
    chk("R13 settle done", int'(mode_o), 0);

    // sync latency and hardware standby outputs
    stby_req_ni = 1'b0; sleep_cmd_i = 1'b1; cyc(2);
    sleep_cmd_i = 1'b0;
    chk("R1 no early change", int'(mode_o), 1);
    pulse(irq_i);
    chk("R8 back to run", int'(mode_o), 0);
    cyc(1);
    chk("R8 then hw", int'(mode_o), 4);
    chk("R4 clk_en", int'(clk_en_o), 4'b0001);
    chk("R4 tmu", int'(tmu_en_o), 0);
    chk("R4 tclk", int'(tclk_o), 0);
    chk("R5 accept", int'(accept_o), 0);
    pulse(irq_i); pulse(mrst_req_i); cyc(2);
    chk("R5 wake ignored", int'(mode_o), 4);

    stby_req_ni = 1'b1; cyc(6);
    chk("R9 por high stays", int'(mode_o), 4);
    stby_req_ni = 1'b0; por_ni = 1'b0; cyc(4);
    stby_req_ni = 1'b1; cyc(2);
    chk("R1 sync 2 edges", int'(mode_o), 4);
    cyc(1);
    chk("R9 osc restart", int'(mode_o), 5);
    chk("R5 osc accept", int'(accept_o), 0);
    cyc(STAB - 1);
    chk("R11 not yet stable", int'(osc_stable_o), 0);
    cyc(1);
    chk("R11 stable", int'(osc_stable_o), 1);
    por_ni = 1'b1; cyc(3);
    chk("R10 run", int'(mode_o), 0);
    chk("R10 pulse", int'(por_start_o), 1);
    chk("R11 not early", int'(osc_early_o), 0);
    cyc(1);
    chk("R10 pulse ends", int'(por_start_o), 0);

    // early release
    stby_req_ni = 1'b0; cyc(4);
    chk("R3 run to hw", int'(mode_o), 4);
    por_ni = 1'b0; stby_req_ni = 1'b1; cyc(8);
    chk("R11 cleared", int'(osc_stable_o), 0);
    por_ni = 1'b1; cyc(3);
    chk("R11 early", int'(osc_early_o), 1);
    chk("R10 early run", int'(mode_o), 0);

    // osc restart aborted by request
    stby_req_ni = 1'b0; cyc(4);
    por_ni = 1'b0; stby_req_ni = 1'b1; cyc(4);
    chk("R9 osc again", int'(mode_o), 5);
    chk("R11 early cleared", int'(osc_early_o), 0);
    stby_req_ni = 1'b0; cyc(3);
    chk("R9 back to hw", int'(mode_o), 4);
    hw_to_run();

    // software standby direct
    pulse(stby_cmd_i);
    stby_req_ni = 1'b0; cyc(2);
    chk("R6 still sw", int'(mode_o), 2);
    cyc(1);
    chk("R6 direct hw", int'(mode_o), 4);
    hw_to_run();

    // settling defers request
    pulse(stby_cmd_i); pulse(mrst_req_i);
    chk("R13 mrst to settle", int'(mode_o), 3);
    stby_req_ni = 1'b0; cyc(6);
    chk("R7 settle holds", int'(mode_o), 3);
    pulse(wdt_done_i);
    chk("R7 run first", int'(mode_o), 0);
    cyc(1);
    chk("R7 then hw", int'(mode_o), 4);
    hw_to_run();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      irq_i       = ($urandom_range(15) == 0);
      mrst_req_i  = ($urandom_range(63) == 0);
      sleep_cmd_i = ($urandom_range(15) == 0);
      stby_cmd_i  = ($urandom_range(15) == 0);
      wdt_done_i  = ($urandom_range(7) == 0);
      if ($urandom_range(23) == 0) stby_req_ni = ~stby_req_ni;
      if ($urandom_range(31) == 0) por_ni = ~por_ni;
      cyc(1);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule